// File: doc/BRIEF.md
# Shift-Register Reload Clock-Enable Divider

This block divides a stream of input enable cycles by a programmable ratio and produces a one-cycle tick plus a square toggle output. Its count element is a 6-bit maximal-length shift register, not a binary counter. The divide ratio is not written as a binary number. It is written as a reload code: the register state that lies N-1 steps before a fixed terminal state. When the register reaches the terminal state, it emits a tick, flips the toggle output and reloads the code.

Software picks the code for a wanted ratio from the register's own sequence. A write is buffered and only used at the next terminal event, so a running period is never cut short or stretched. The lock-up state of the register is reserved as a bypass code for divide-by-one.

Top module: `lfsr_reload_div`

## Requirements
- R1: While rst is high and in the cycle after it is released, tickOut and divOut are 0. The code in force after reset is the bypass code 6'h3f.
- R2: One step takes the state s to {s[4:0], ~(s[5]^s[4])}. This gives a 63-state cycle that never enters 6'h3f. The terminal state is 6'h01. For every ratio N from 2 to 64, loading the state found N-1 steps before 6'h01 gives ticks exactly N enabled cycles apart.
- R3: Known codes give these ratios: 6'h00 gives 2, 6'h20 gives 3, 6'h10 gives 4, 6'h03 gives 63 and 6'h01 gives 64. Code 6'h01 runs the full 63-step cycle before its tick, not zero steps.
- R4: tickOut is high for exactly one clock. It is high in the cycle after the clock edge that samples enIn high while the terminal event occurs.
- R5: divOut inverts in the same cycle that tickOut is high and holds its value otherwise.
- R6: Code 6'h3f selects bypass. Every enabled cycle is then a terminal event, so the ratio is 1.
- R7: A cycle with enIn low does not step the register, does not tick and does not change divOut.
- R8: A code written with codeWrEn is used only from the next terminal event on. The period in progress when the write occurs keeps the length of the previous code.
- R9: A write in the same enabled cycle as a terminal event is forwarded. The new code governs the period that starts at that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enIn | input | 1 | Input enable; only cycles with enIn high are counted |
| codeWrEn | input | 1 | Write strobe for the reload code |
| codeWrData | input | 6 | Reload code to store |
| tickOut | output | 1 | One-cycle pulse per divided period |
| divOut | output | 1 | Toggles on every tick (half the tick rate) |

## Verification
A code write and a terminal event can land on the same enabled cycle. The design must then use the newly written code for the period that starts there, not the old one.

The bench provokes this case directly. It synchronises to a tick under a known ratio, counts off exactly that many enabled cycles, and raises codeWrEn on the last of them. It then checks two things: the closing interval still has the old length, and the next interval has the new length. A second directed case writes a code in the middle of a period and checks that the period in progress is not shortened.

// File: rtl/lfsr_div_pkg.sv
package lfsr_div_pkg;
  localparam int unsigned LFSR_W    = 6;
  localparam int unsigned TAP_HI    = 5;
  localparam int unsigned TAP_LO    = 4;
  localparam logic [LFSR_W-1:0] TERM_STATE  = 6'h01;
  localparam logic [LFSR_W-1:0] BYPASS_CODE = 6'h3f;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;   // terminal event this cycle
    logic load;   // reload the shift register
    logic step;   // advance the shift register
  } divStrb_t;
endpackage

// File: rtl/lfsr_div_ctrl.sv
module lfsr_div_ctrl
  import lfsr_div_pkg::*;
#(
  parameter int unsigned W = LFSR_W,
  parameter logic [W-1:0] TermState  = TERM_STATE,
  parameter logic [W-1:0] BypassCode = BYPASS_CODE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enIn,
  input  logic         codeWrEn,
  input  logic [W-1:0] codeWrData,
  input  logic         atTerm,
  output divStrb_t     strb,
  output logic [W-1:0] loadCode
);
  logic [W-1:0] pendingCode;
  logic [W-1:0] activeCode;
  logic [W-1:0] nextCode;
  logic         fresh;      // register was just reloaded, terminal check masked
  logic         bypassOn;
  logic         termEvt;

  // a write in the terminal cycle is forwarded to the reload
  assign nextCode = codeWrEn ? codeWrData : pendingCode;
  assign bypassOn = (activeCode == BypassCode);
  assign termEvt  = enIn && (bypassOn || (atTerm && !fresh));

  always_comb begin
    strb.tick = termEvt;
    strb.load = termEvt;
    strb.step = enIn && !termEvt;
  end
  assign loadCode = nextCode;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendingCode <= BypassCode;
      activeCode  <= BypassCode;
      fresh       <= 1'b1;
    end else begin
      pendingCode <= nextCode;
      if (termEvt) begin
        activeCode <= nextCode;
        fresh      <= 1'b1;
      end else if (enIn) begin
        fresh      <= 1'b0;
      end
    end
  end

  AST_PENDING_HOLD: assert property (@(posedge clk) disable iff (rst)
    !codeWrEn |=> $stable(pendingCode)); // R8
  AST_ACTIVE_AT_TERM: assert property (@(posedge clk) disable iff (rst)
    !strb.tick |=> $stable(activeCode)); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(strb.step && strb.load)); // R4
endmodule

// File: rtl/lfsr_div_datapath.sv
module lfsr_div_datapath
  import lfsr_div_pkg::*;
#(
  parameter int unsigned W = LFSR_W,
  parameter int unsigned TapHi = TAP_HI,
  parameter int unsigned TapLo = TAP_LO,
  parameter logic [W-1:0] TermState  = TERM_STATE,
  parameter logic [W-1:0] BypassCode = BYPASS_CODE
) (
  input  logic         clk,
  input  logic         rst,
  input  divStrb_t     strb,
  input  logic [W-1:0] loadCode,
  output logic         atTerm,
  output logic         tickOut,
  output logic         divOut
);
  logic [W-1:0] lfsrQ;
  logic [W-1:0] lfsrStep;

  assign lfsrStep = {lfsrQ[W-2:0], ~(lfsrQ[TapHi] ^ lfsrQ[TapLo])};
  assign atTerm   = (lfsrQ == TermState);

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsrQ   <= BypassCode;
      tickOut <= 1'b0;
      divOut  <= 1'b0;
    end else begin
      if (strb.load)      lfsrQ <= loadCode;
      else if (strb.step) lfsrQ <= lfsrStep;
      tickOut <= strb.tick;
      if (strb.tick) divOut <= ~divOut;
    end
  end

  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
    (strb.step && lfsrQ != BypassCode) |=> (lfsrQ != BypassCode)); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> (lfsrQ == $past(loadCode))); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!strb.load && !strb.step) |=> $stable(lfsrQ)); // R7
endmodule

// File: rtl/lfsr_reload_div.sv
module lfsr_reload_div
  import lfsr_div_pkg::*;
#(
  parameter int unsigned W = LFSR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enIn,
  input  logic         codeWrEn,
  input  logic [W-1:0] codeWrData,
  output logic         tickOut,
  output logic         divOut
);
  divStrb_t     strb;
  logic [W-1:0] loadCode;
  logic         atTerm;
  logic         runFlag;

  lfsr_div_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .enIn(enIn), .codeWrEn(codeWrEn),
    .codeWrData(codeWrData), .atTerm(atTerm), .strb(strb), .loadCode(loadCode)
  );

  lfsr_div_datapath #(.W(W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .loadCode(loadCode),
    .atTerm(atTerm), .tickOut(tickOut), .divOut(divOut)
  );

  // marks that the previous sampled values are post-reset
  always_ff @(posedge clk) begin
    if (rst) runFlag <= 1'b0;
    else     runFlag <= 1'b1;
  end

  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    tickOut |-> $past(enIn)); // R7
  AST_DIV_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (rst)
    runFlag |-> ((divOut ^ $past(divOut)) == tickOut)); // R5
  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (runFlag && tickOut && !$past(enIn)) |-> 1'b0); // R4
endmodule

// File: tb/lfsr_reload_div_tb.sv
`timescale 1ns/1ps
module lfsr_reload_div_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enIn = 1'b0;
  logic codeWrEn = 1'b0;
  logic [5:0] codeWrData = 6'h0;
  logic tickOut, divOut;

  int checks = 0;
  int failures = 0;
  int enCnt = 0;
  int lastIv = 0;
  bit tickFlag = 0;
  bit prevDiv = 0;
  int togErr = 0;
  int noEnErr = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lfsr_reload_div u_dut (
    .clk(clk), .rst(rst), .enIn(enIn), .codeWrEn(codeWrEn),
    .codeWrData(codeWrData), .tickOut(tickOut), .divOut(divOut)
  );

  // predecessor under the stepping rule: inverse of {s[4:0], ~(s5^s4)}
  function automatic logic [5:0] prevState(input logic [5:0] s);
    return {~s[0] ^ s[5], s[5:1]};
  endfunction

  function automatic logic [5:0] codeFor(input int n);
    logic [5:0] s = 6'h01;
    if (n == 1) return 6'h3f;
    for (int i = 1; i < n; i++) s = prevState(s);
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step1(input bit en, input bit wr, input logic [5:0] d);
    @(negedge clk);
    enIn = en; codeWrEn = wr; codeWrData = d;
    @(posedge clk); #1;
    if (en) enCnt++;
    if (tickOut) begin
      if (!en) noEnErr++;
      lastIv = enCnt; enCnt = 0; tickFlag = 1;
    end else tickFlag = 0;
    if (divOut !== (prevDiv ^ tickOut)) togErr++;
    prevDiv = divOut;
  endtask

  task automatic waitTick(input bit randEn, output bit ok);
    ok = 0;
    for (int i = 0; i < 1000; i++) begin
      step1(randEn ? (($urandom % 10) < 7) : 1'b1, 1'b0, 6'h0);
      if (tickFlag) begin ok = 1; break; end
    end
  endtask

  task automatic measure(input logic [5:0] code, input int n, input bit randEn, input string req);
    bit ok;
    step1(1'b0, 1'b1, code);
    waitTick(randEn, ok);           // new code takes over here
    for (int k = 0; k < 2; k++) begin
      waitTick(randEn, ok);
      chk(ok && lastIv == n, req, ok ? lastIv : -1, n);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit ok;
    int n;
    int s0;
    s0 = $urandom(32'h00c0ffee);
    repeat (3) @(posedge clk);
    #1;
    chk(tickOut == 0 && divOut == 0, "R1 in reset", {tickOut, divOut}, 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    chk(tickOut == 0 && divOut == 0, "R1 after release", {tickOut, divOut}, 0);
    prevDiv = divOut;

    // default bypass: tick every enabled cycle
    begin
      int tk = 0;
      for (int i = 0; i < 4; i++) begin step1(1'b1, 1'b0, 6'h0); tk += tickOut; end
      chk(tk == 4, "R1 R6 bypass default", tk, 4);
    end

    // disabled cycles: nothing moves
    begin
      int tk = 0; bit d0 = divOut;
      for (int i = 0; i < 5; i++) begin step1(1'b0, 1'b0, 6'h0); tk += tickOut; end
      chk(tk == 0 && divOut == d0, "R7 enable low", tk, 0);
    end

    // stated codes
    measure(6'h00, 2,  1'b0, "R3 code 00");
    measure(6'h20, 3,  1'b0, "R3 code 20");
    measure(6'h10, 4,  1'b0, "R3 code 10");
    measure(6'h03, 63, 1'b1, "R3 code 03");
    measure(6'h01, 64, 1'b1, "R3 code 01");
    measure(6'h3f, 1,  1'b1, "R6 bypass code");

    // full sweep against bench-computed codes, random enable
    for (int d = 1; d <= 64; d++) measure(codeFor(d), d, 1'b1, "R2 sweep");

    // random divisors
    for (int r = 0; r < 8; r++) begin
      n = 1 + ($urandom % 64);
      measure(codeFor(n), n, 1'b1, "R2 random");
    end

    // R8: mid-period write must not truncate
    measure(codeFor(20), 20, 1'b0, "R8 setup");
    for (int i = 0; i < 5; i++) step1(1'b1, 1'b0, 6'h0);
    step1(1'b1, 1'b1, codeFor(3));
    waitTick(1'b0, ok);
    chk(ok && lastIv == 20, "R8 period kept", lastIv, 20);
    waitTick(1'b0, ok);
    chk(ok && lastIv == 3, "R8 new code next", lastIv, 3);

    // R9: write lands on the terminal cycle
    measure(codeFor(10), 10, 1'b0, "R9 setup");
    for (int i = 0; i < 9; i++) step1(1'b1, 1'b0, 6'h0);
    step1(1'b1, 1'b1, codeFor(5));
    chk(tickFlag && lastIv == 10, "R9 terminal with write", lastIv, 10);
    waitTick(1'b0, ok);
    chk(ok && lastIv == 5, "R9 forwarded code", lastIv, 5);

    // R4: tick never lasts while enable is off
    step1(1'b0, 1'b0, 6'h0);
    chk(tickOut == 0, "R4 single-cycle pulse", tickOut, 0);

    chk(togErr == 0, "R5 divOut toggle", togErr, 0);
    chk(noEnErr == 0, "R7 tick without enable", noEnErr, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule